// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches up to 81 digital input pins and raises a single interrupt request when a pin whose enable bit is set moves away from its remembered level. Software sets the per-pin enables through a small register port of 16-bit words. It takes a snapshot of the pin levels by reading the port image, and that snapshot becomes the reference that later changes are measured against.

Two detection paths run side by side. A clocked path brings each pin through two synchronizer flops, compares it with the reference, and sets a sticky interrupt flag. An unclocked path combines the live pins, the reference and the enables with plain gates, so a change can still signal a wake request while the main clock is stopped. The block also stores per-pin pull-up and pull-down control bits for the pad drivers. Any pin that is set as an output has its pull-up forced off.

Top module: `change_notify`

## Requirements
- R1: After reset, all enable, pull-up, pull-down and reference bits are zero, and `irq_o`, `wake_o`, `pull_up_o` and `pull_down_o` are all zero.
- R2: `addr_i[4:3]` selects the bank (0 = interrupt enables, 1 = pull-up enables, 2 = pull-down enables, 3 = port image) and `addr_i[2:0]` selects the 16-bit word. Bit b of word w maps to pin 16*w+b. A written enable, pull-up or pull-down word reads back unchanged.
- R3: Bits for pins at or above NPINS in the last word are ignored on write and always read as zero.
- R4: `wake_o` is high, through gates only and with no clock edge needed, whenever an enabled pin differs from its reference bit.
- R5: A change on an enabled pin sets `irq_o` at the third rising clock edge after the change. A change on a pin that is not enabled affects neither `irq_o` nor `wake_o`.
- R6: `irq_o` stays set until software writes a 1 to bit 0 at address 31. Writing a 0 there leaves it set.
- R7: A read of bank 3, word w returns the synchronized pin levels of that word and loads them into the reference for that word. After the read, the mismatch and `wake_o` for those pins clear.
- R8: A read of address 31 returns the interrupt flag in bit 0 and zeros in all other bits.
- R9: `pull_up_o` is the stored pull-up bit AND NOT `pin_out_i` for each pin. `pull_down_o` is the stored pull-down bit regardless of direction.
- R10: A write to a word index at or beyond the number of words (for example address 6 with 81 pins) changes nothing, and that address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock (may be stopped) |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NPINS | Live pin levels |
| pin_out_i | input | NPINS | 1 where the pin is a digital output |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (port reads update reference) |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| pull_up_o | output | NPINS | Pull-up enables to pads |
| pull_down_o | output | NPINS | Pull-down enables to pads |
| irq_o | output | 1 | Sticky interrupt request |
| wake_o | output | 1 | Unclocked wake request |

## Verification
The bench stops the clock, moves an enabled pin, and expects `wake_o` to rise anyway. A design that sampled the wake path through flops would stay silent there. It times the flag to the exact third edge after a pin change, so an extra or missing synchronizer stage shows up as a wrong cycle. It also moves a pin that is not enabled, which exposes a design that ignores the enables. The bench writes a zero to the clear bit and then a one, which catches a flag that is not sticky or that clears on any write. It also drives ones into the padding bits of the last word and into a word that does not exist, and expects zeros back.

// File: rtl/change_notify.sv
module change_notify #(
  parameter int NPINS = 81
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] pin_out_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [4:0]       addr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  output logic [NPINS-1:0] pull_up_o,
  output logic [NPINS-1:0] pull_down_o,
  output logic             irq_o,
  output logic             wake_o
);
  localparam int WORDS = (NPINS + 15) / 16;
  localparam int PADW  = WORDS * 16;
  localparam logic [PADW-1:0] VALID = ~({PADW{1'b1}} << NPINS);

  logic [PADW-1:0] en_q, pu_q, pd_q, ref_q, s1_q, s2_q, pins_pad, mism;
  logic [1:0] bank;
  logic [2:0] word;
  logic word_ok, clr, irq_q;

  assign bank     = addr_i[4:3];
  assign word     = addr_i[2:0];
  assign word_ok  = 32'(word) < WORDS;
  assign clr      = wr_en_i && addr_i == 5'd31 && wdata_i[0];
  assign pins_pad = PADW'(pins_i);
  assign mism     = en_q & (s2_q ^ ref_q);

  assign wake_o      = |(en_q & (pins_pad ^ ref_q));
  assign irq_o       = irq_q;
  assign pull_up_o   = pu_q[NPINS-1:0] & ~pin_out_i;
  assign pull_down_o = pd_q[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pins_pad;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pu_q  <= '0;
      pd_q  <= '0;
      ref_q <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (32'(word) == w) begin
          if (wr_en_i && bank == 2'd0) en_q[w*16 +: 16] <= wdata_i & VALID[w*16 +: 16];
          if (wr_en_i && bank == 2'd1) pu_q[w*16 +: 16] <= wdata_i & VALID[w*16 +: 16];
          if (wr_en_i && bank == 2'd2) pd_q[w*16 +: 16] <= wdata_i & VALID[w*16 +: 16];
          if (rd_en_i && bank == 2'd3) ref_q[w*16 +: 16] <= s2_q[w*16 +: 16];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (irq_q & ~clr) | (|mism);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == 5'd31) rdata_o = {15'd0, irq_q};
    else if (word_ok) begin
      case (bank)
        2'd0:    rdata_o = en_q[{word, 4'b0} +: 16];
        2'd1:    rdata_o = pu_q[{word, 4'b0} +: 16];
        2'd2:    rdata_o = pd_q[{word, 4'b0} +: 16];
        default: rdata_o = s2_q[{word, 4'b0} +: 16];
      endcase
    end
  end

  assert_pad_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q | pu_q | pd_q | ref_q) & ~VALID) == '0);
  assert_no_wake_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !wake_o);
  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|en_q));
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q);
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && mism == '0) |=> !irq_q);
  assert_pullup_off_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up_o & pin_out_i) == '0);
endmodule

// File: tb/sim_change_notify.sv
`timescale 1ns/1ps
module sim_change_notify;
  localparam int N = 81;
  logic clk = 0, clk_run = 1, rst_n = 0;
  logic [N-1:0] pins = '0, pout = '0;
  logic wr = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [N-1:0] pu, pd;
  logic irq, wake;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 if (clk_run) clk = ~clk;

  change_notify #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .pin_out_i(pout),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pull_up_o(pu), .pull_down_o(pd),
    .irq_o(irq), .wake_o(wake));

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  localparam int NV = 7;
  localparam logic [4:0]  VA [NV] = '{5'd0, 5'd5, 5'd10, 5'd21, 5'd17, 5'd6, 5'd13};
  localparam logic [15:0] VD [NV] = '{16'hA5A5, 16'hFFFF, 16'h1234, 16'h00FF, 16'hBEEF, 16'hFFFF, 16'hFFFF};
  localparam logic [15:0] VE [NV] = '{16'hA5A5, 16'h0001, 16'h1234, 16'h0001, 16'hBEEF, 16'h0000, 16'h0001};

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 96'(irq), 96'(0));
    chk("R1 wake", 96'(wake), 96'(0));
    chk("R1 pulls", 96'(pu | pd), 96'(0));
    rst_n = 1;
    rreg(5'd0, d); chk("R1 en word0", 96'(d), 96'(0));

    // R2 R3 R10 vector table
    for (int i = 0; i < NV; i++) begin
      wreg(VA[i], VD[i]);
      rreg(VA[i], d);
      chk("R2/R3/R10 readback", 96'(d), 96'(VE[i]));
    end
    // clear enables back to zero
    for (int w = 0; w < 6; w++) wreg(5'(w), 16'h0);

    // R9 pull-up gating
    wreg(5'd8, 16'hFFFF); wreg(5'd16, 16'h000F);
    @(negedge clk); pout[0] = 1; pout[2] = 1; #1;
    chk("R9 pull-up", 96'(pu[15:0]), 96'(16'hFFFA));
    chk("R9 pull-down", 96'(pd[15:0]), 96'(16'h000F));

    // reference snapshot
    for (int w = 0; w < 6; w++) rreg(5'(24 + w), d);
    wreg(5'd0, 16'h0008);

    // R5 disabled pin
    @(negedge clk); pins[4] = 1;
    repeat (4) @(negedge clk);
    chk("R5 disabled irq", 96'(irq), 96'(0));
    chk("R5 disabled wake", 96'(wake), 96'(0));

    // R4 R5 enabled pin timing
    pins[3] = 1; #1;
    chk("R4 wake immediate", 96'(wake), 96'(1));
    @(negedge clk); @(negedge clk);
    chk("R5 irq not yet", 96'(irq), 96'(0));
    @(negedge clk);
    chk("R5 irq on third edge", 96'(irq), 96'(1));

    // R6 write of 0 keeps flag, R8 status read
    wreg(5'd31, 16'h0000);
    chk("R6 zero write keeps", 96'(irq), 96'(1));
    rreg(5'd31, d); chk("R8 status set", 96'(d), 96'(1));

    // R7 port read
    rreg(5'd24, d);
    chk("R7 port value", 96'(d), 96'(16'h0018));
    chk("R7 wake cleared", 96'(wake), 96'(0));
    wreg(5'd31, 16'h0001);
    chk("R6 cleared", 96'(irq), 96'(0));
    rreg(5'd31, d); chk("R8 status clear", 96'(d), 96'(0));

    // R4 wake with clock stopped, top pin
    wreg(5'd5, 16'h0001);
    @(negedge clk); clk_run = 0;
    #20 pins[80] = 1; #1;
    chk("R4 wake clock stopped", 96'(wake), 96'(1));
    chk("R4 irq frozen", 96'(irq), 96'(0));
    #10 clk_run = 1;
    repeat (4) @(negedge clk);
    chk("R5 irq after restart", 96'(irq), 96'(1));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule